// File: doc/BRIEF.md
# Low-Level Wake-Up Qualifier

This block brings a device out of deep sleep when an external interrupt pin is held low. In deep sleep the I/O clock is stopped. The block therefore runs only on a slow, always-on oscillator clock, which samples the pin once per cycle. Two consecutive low samples start a wake-up and a start-up timer. The timer length comes from a 2-bit select code.

When the timer expires, the block emits a one-cycle wake pulse. In the same cycle it reports whether the low level is still present. A low level at that point means an interrupt should be raised along with the wake. If the level has gone away, the device wakes and no interrupt is raised. The block works only while the sleep indication shows a mode other than idle and the channel is configured for low-level sense. At all other times it is held in its sleep-waiting state.

The controller has four states. SLEEP waits for a low sample and moves to QUALIFY. QUALIFY moves to STARTUP on a second consecutive low sample and returns to SLEEP on a high sample. STARTUP counts the selected number of cycles and then moves to AWAKE. AWAKE holds until the enable condition drops, then returns to SLEEP. Whenever the enable condition is false, the state is forced to SLEEP.

Top module: `lw_wake_top`

## Requirements
- R1: No wake pulse is produced unless sleep_deep_i is 1 and sense_low_i is 1; dropping either one forces the controller back to SLEEP.
- R2: A single low sample followed by a high sample returns QUALIFY to SLEEP, and no wake pulse follows.
- R3: sut_sel_i selects the start-up length: 0 gives 4 cycles, 1 gives 64, 2 gives 512 and 3 gives 4096. Take the first rising edge of clk_slow_i after pin_i goes low as edge 1. The wake pulse is then high after edge length+3.
- R4: wake_o is high for exactly one clock cycle per wake-up.
- R5: If pin_i is still low at the end of start-up, irq_qual_o is 1 in the cycle of the wake pulse.
- R6: If pin_i passed the two-sample check but went high well before start-up ended, the wake pulse is still produced and irq_qual_o is 0.
- R7: irq_qual_o is never 1 outside the wake pulse cycle.
- R8: After reset, wake_o and irq_qual_o are 0. While the controller stays in AWAKE, no further pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Always-on slow oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External interrupt pin, active low |
| sleep_deep_i | input | 1 | 1 when in a sleep mode other than idle |
| sense_low_i | input | 1 | 1 when the channel is set to low-level sense |
| sut_sel_i | input | 2 | Start-up length select code |
| wake_o | output | 1 | One-cycle wake pulse |
| irq_qual_o | output | 1 | Level still present at wake (interrupt allowed) |

## Verification
The pin is driven with three kinds of low pulse. A level held through start-up must produce a wake with the interrupt qualified. A two-sample low pulse must produce a wake without an interrupt. A one-sample glitch must produce no wake at all, which separates the two-sample filter from a single-sample one. Each kind is tried under random select codes and a directed longest code, so the pulse timing exposes any off-by-one error in the timer. Long low levels with either enable condition cleared show that the gating blocks the wake path.

// File: rtl/lw_pkg.sv
package lw_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_STARTUP = 2'd2,
        ST_AWAKE   = 2'd3
    } lw_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/lw_sampler.sv
module lw_sampler (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic samp_o
);
    // One sample per slow cycle; idle value is high (no request).
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) samp_o <= 1'b1;
        else         samp_o <= pin_i;
    end
endmodule

// File: rtl/lw_timer.sv
module lw_timer #(
    parameter int LEN0 = 4,
    parameter int LEN1 = 64,
    parameter int LEN2 = 512,
    parameter int LEN3 = 4096,
    localparam int CNT_W = $clog2(lw_pkg::max4(LEN0, LEN1, LEN2, LEN3) + 1)
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic [1:0] sel_i,
    output logic       done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        unique case (sel_i)
            2'd0:    last = CNT_W'(LEN0 - 1);
            2'd1:    last = CNT_W'(LEN1 - 1);
            2'd2:    last = CNT_W'(LEN2 - 1);
            default: last = CNT_W'(LEN3 - 1);
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (clr_i)   cnt_q <= '0;
        else if (run_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == last);
endmodule

// File: rtl/lw_fsm.sv
module lw_fsm
    import lw_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      en_i,
    input  logic      samp_i,
    input  logic      done_i,
    output lw_state_e state_o,
    output logic      tmr_clr_o,
    output logic      tmr_run_o,
    output logic      wake_o,
    output logic      irq_qual_o
);
    lw_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = ST_SLEEP;
        end else begin
            unique case (st_q)
                ST_SLEEP:   if (!samp_i) st_d = ST_QUALIFY;
                ST_QUALIFY: st_d = samp_i ? ST_SLEEP : ST_STARTUP;
                ST_STARTUP: if (done_i) st_d = ST_AWAKE;
                ST_AWAKE:   st_d = ST_AWAKE;
                default:    st_d = ST_SLEEP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_SLEEP;
        else         st_q <= st_d;
    end

    // Registered outputs: pulse on the STARTUP -> AWAKE move
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wake_o     <= 1'b0;
            irq_qual_o <= 1'b0;
        end else begin
            wake_o     <= en_i && (st_q == ST_STARTUP) && done_i;
            irq_qual_o <= en_i && (st_q == ST_STARTUP) && done_i && !samp_i;
        end
    end

    assign tmr_clr_o = (st_q != ST_STARTUP);
    assign tmr_run_o = en_i && (st_q == ST_STARTUP);
    assign state_o   = st_q;
endmodule

// File: rtl/lw_wake_top.sv
module lw_wake_top #(
    parameter int LEN0 = 4,
    parameter int LEN1 = 64,
    parameter int LEN2 = 512,
    parameter int LEN3 = 4096
) (
    input  logic       clk_slow_i,
    input  logic       rst_ni,
    input  logic       pin_i,
    input  logic       sleep_deep_i,
    input  logic       sense_low_i,
    input  logic [1:0] sut_sel_i,
    output logic       wake_o,
    output logic       irq_qual_o
);
    import lw_pkg::*;

    logic      en;
    logic      samp;
    logic      done;
    logic      tmr_clr;
    logic      tmr_run;
    lw_state_e state;

    assign en = sleep_deep_i && sense_low_i;

    lw_sampler u_samp (
        .clk_i  (clk_slow_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .samp_o (samp)
    );

    lw_timer #(.LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)) u_tmr (
        .clk_i  (clk_slow_i),
        .rst_ni (rst_ni),
        .clr_i  (tmr_clr),
        .run_i  (tmr_run),
        .sel_i  (sut_sel_i),
        .done_o (done)
    );

    lw_fsm u_fsm (
        .clk_i      (clk_slow_i),
        .rst_ni     (rst_ni),
        .en_i       (en),
        .samp_i     (samp),
        .done_i     (done),
        .state_o    (state),
        .tmr_clr_o  (tmr_clr),
        .tmr_run_o  (tmr_run),
        .wake_o     (wake_o),
        .irq_qual_o (irq_qual_o)
    );
endmodule

// File: rtl/lw_wake_chk.sv
module lw_wake_chk
    import lw_pkg::*;
(
    input logic      clk_slow_i,
    input logic      rst_ni,
    input logic      pin_i,
    input logic      sleep_deep_i,
    input logic      sense_low_i,
    input logic      wake_o,
    input logic      irq_qual_o,
    input logic      samp,
    input lw_state_e state
);
    AST_GATED_OFF: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
        !(sleep_deep_i && sense_low_i) |=> (!wake_o && state == ST_SLEEP)); // R1

    AST_HIGH_ABORTS: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
        (state == ST_QUALIFY && samp) |=> (state == ST_SLEEP)); // R2

    AST_ONE_PULSE: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
        wake_o |=> !wake_o); // R4

    AST_QUAL_LEVEL: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
        irq_qual_o |-> !$past(pin_i, 2)); // R5

    AST_QUAL_WITH_WAKE: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
        irq_qual_o |-> wake_o); // R7

    AST_AWAKE_QUIET: assert property (@(posedge clk_slow_i) disable iff (!rst_ni)
        (state == ST_AWAKE && $past(state) == ST_AWAKE) |-> !wake_o); // R8
endmodule

bind lw_wake_top lw_wake_chk u_chk (
    .clk_slow_i   (clk_slow_i),
    .rst_ni       (rst_ni),
    .pin_i        (pin_i),
    .sleep_deep_i (sleep_deep_i),
    .sense_low_i  (sense_low_i),
    .wake_o       (wake_o),
    .irq_qual_o   (irq_qual_o),
    .samp         (samp),
    .state        (state)
);

// File: tb/lw_wake_top_tb.sv
module lw_wake_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic       deep = 1'b1;
    logic       sense = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       wake;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    lw_wake_top u_dut (
        .clk_slow_i   (clk),
        .rst_ni       (rst_n),
        .pin_i        (pin),
        .sleep_deep_i (deep),
        .sense_low_i  (sense),
        .sut_sel_i    (sel),
        .wake_o       (wake),
        .irq_qual_o   (irq)
    );

    function automatic int exp_len(input logic [1:0] c);
        case (c)
            2'd0: return 4;
            2'd1: return 64;
            2'd2: return 512;
            default: return 4096;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic recover();
        pin  = 1'b1;
        deep = 1'b0;
        repeat (3) @(negedge clk);
        check(wake == 1'b0, "R1", wake, 0);
        deep = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // kind 0: held low, 1: two-sample pulse, 2: one-sample glitch
    task automatic run_case(input logic [1:0] code, input int kind);
        int len;
        int wake_at;
        int irq_at;
        int pulses;
        int width;
        len = exp_len(code);
        sel = code;
        wake_at = -1; irq_at = 0; pulses = 0; width = 0;
        @(negedge clk);
        pin = 1'b0;
        for (int i = 1; i <= len + 10; i++) begin
            @(negedge clk);
            if (kind == 1 && i == 2) pin = 1'b1;
            if (kind == 2 && i == 1) pin = 1'b1;
            if (wake) begin
                width++;
                if (wake_at < 0) begin
                    wake_at = i;
                    irq_at  = irq;
                    pulses++;
                end
            end else if (irq) begin
                check(1'b0, "R7", irq, 0);
            end
        end
        if (kind == 2) begin
            check(wake_at < 0, "R2", wake_at, -1);
        end else begin
            check(wake_at == len + 3, "R3", wake_at, len + 3);
            check(width == 1, "R4", width, 1);
            if (kind == 0) check(irq_at == 1, "R5", irq_at, 1);
            else           check(irq_at == 0, "R6", irq_at, 0);
        end
        check(wake == 1'b0, "R8", wake, 0);
        recover();
    endtask

    task automatic gated(input logic d, input logic s);
        int seen;
        seen = 0;
        deep = d; sense = s; sel = 2'd0;
        @(negedge clk);
        pin = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wake) seen++;
        end
        check(seen == 0, "R1", seen, 0);
        pin = 1'b1; deep = 1'b1; sense = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(wake == 1'b0 && irq == 1'b0, "R8", {wake, irq}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(wake == 1'b0 && irq == 1'b0, "R8", {wake, irq}, 0);

        run_case(2'd0, 0);
        run_case(2'd0, 1);
        run_case(2'd0, 2);
        run_case(2'd1, 0);
        run_case(2'd3, 0);
        run_case(2'd3, 1);
        gated(1'b1, 1'b0);
        gated(1'b0, 1'b1);

        for (int n = 0; n < 24; n++) begin
            logic [1:0] c;
            int k;
            c = 2'($urandom_range(0, 2));
            k = int'($urandom_range(0, 2));
            run_case(c, k);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule